// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block runs chains of transfer descriptors for several DMA channels. Each descriptor sits in memory as five 32-bit words: a channel control word, a source address, a destination address, a count word that carries flag bits, and a pointer to the next descriptor. Software writes a channel's first descriptor address and then starts the channel through a shared command register. The sequencer reads the descriptor over a memory read port and loads the control word into the channel. It then passes the source, the destination and the byte length to an external data mover. It counts down the mover's beat reports and, when the count is used up, either follows the link to the next descriptor or stops.

The interrupt flags in each count word decide whether that descriptor raises a completion pulse, so a chain normally interrupts only at its end. A channel-level enable in the control word gates all of these flags. Software can halt a channel at any time. The descriptor address register and the count register then show where the walk stopped and how many units were left.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset every channel is idle: the command register reads 0, mem_valid, xfer_req and irq are all 0.
- R2: A write to the command register (offset 0x80) changes channel c only when mask bit 16+c is set in the same write. Bit c set then starts the channel and bit c clear halts it. Without the mask bit the channel keeps its state.
- R3: A started channel reads words at its descriptor address plus 0, 4, 8, 12 and 16, taken as control, source, destination, count and next pointer. After the fifth word is accepted, the control word is copied into the channel control register (offset 0x40+8c).
- R4: During a transfer, xfer_req is high and the block presents the source, the destination and the byte length. The byte length is the count units (count bits 15:0) shifted left by control bits 2:1 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit bus). Each xfer_beat takes one unit off the count register, and xfer_req falls once the count is zero.
- R5: When a descriptor finishes and count bit 31 (link) is set, the next pointer goes into the descriptor address register and a new fetch begins. When the link bit is clear, the channel stops, its command bit reads 0 and the descriptor address register keeps the last descriptor's address.
- R6: A one-cycle irq pulse follows the cycle in which a descriptor's count is zero, provided control bit 0 (channel interrupt enable) is set and either count bit 30 (terminal count) is set, or count bit 29 (end of chain) is set on a descriptor whose link bit is clear. When control bit 0 is clear, no irq is raised.
- R7: A descriptor with zero units finishes without raising xfer_req and still follows its link bit.
- R8: Halting a busy channel drops xfer_req by the next cycle. The descriptor address register keeps the address of the descriptor in progress, and the count register keeps the units still left.
- R9: A read error on any fetched word halts the channel and leaves the descriptor address register at the failing descriptor. It pulses irq if control bit 0 and count bit 28 (error enable) are set in the channel's registers at that moment.
- R10: Register writes to the descriptor address, count or control register of a channel that is not idle are ignored.
- R11: All channels share the memory port. The lowest-numbered fetching channel is served first, and the five reads of one descriptor are not interleaved with another channel's reads. While a read is stalled, the address is held.
- R12: Channel c has its descriptor address register at offset 8c and its count register at offset 8c+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ready | input | 1 | Read accepted; data and error valid this cycle |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read error, qualified by mem_ready |
| xfer_req | output | NCH | Per-channel transfer request |
| xfer_src | output | NCH*32 | Per-channel source address |
| xfer_dst | output | NCH*32 | Per-channel destination address |
| xfer_bytes | output | NCH*(UW+3) | Per-channel remaining byte length |
| xfer_beat | input | NCH | One unit moved for that channel |
| irq | output | NCH | Per-channel interrupt pulse |

## Verification
The halt case is the hardest to reach from the ports. The channel must be caught partway through a descriptor, with an exact number of units already consumed. The bench therefore drives the data mover with a beat budget instead of free-running beats. It waits for xfer_req, issues exactly seven beats, halts the channel, and then reads back the address and residue. The read-error case is reached in a similar way. The memory model is made to fail one chosen word of a linked descriptor, so the error lands after a completed transfer and the error-enable flag already sits in the count register.

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int NCH = 2,
  parameter int UW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [7:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  mem_valid,
  output logic [31:0]           mem_addr,
  input  logic                  mem_ready,
  input  logic [31:0]           mem_rdata,
  input  logic                  mem_err,
  output logic [NCH-1:0]        xfer_req,
  output logic [NCH*32-1:0]     xfer_src,
  output logic [NCH*32-1:0]     xfer_dst,
  output logic [NCH*(UW+3)-1:0] xfer_bytes,
  input  logic [NCH-1:0]        xfer_beat,
  output logic [NCH-1:0]        irq
);
  localparam int BW  = UW + 3;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [7:0] CMD_OFS = 8'h80;
  localparam int LINK_B = 31, TC_B = 30, EOC_B = 29, ERR_B = 28;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} st_t;

  st_t         st  [NCH];
  logic [31:0] dar [NCH];
  logic [31:0] cnt [NCH];
  logic [31:0] ctl [NCH];
  logic [31:0] src [NCH];
  logic [31:0] dst [NCH];
  logic [31:0] nxt [NCH];
  logic [31:0] sh  [4];
  logic [2:0]  widx;
  logic        own_v;
  logic [CHW-1:0] own;
  logic        pick_v;
  logic [CHW-1:0] pick;

  wire cmd_wr = reg_we && (reg_addr == CMD_OFS);
  logic [NCH-1:0] go, halt;
  always_comb
    for (int c = 0; c < NCH; c++) begin
      go[c]   = cmd_wr && reg_wdata[16+c] &&  reg_wdata[c];
      halt[c] = cmd_wr && reg_wdata[16+c] && !reg_wdata[c];
    end

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int c = NCH-1; c >= 0; c--)
      if (st[c] == S_FETCH && !halt[c]) begin
        pick_v = 1'b1;
        pick   = CHW'(c);
      end
  end

  assign mem_valid = own_v && (st[own] == S_FETCH);
  assign mem_addr  = dar[own] + {27'd0, widx, 2'b00};
  wire accept   = mem_valid && mem_ready;
  wire last_wd  = (widx == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v <= 1'b0;
      own   <= '0;
      widx  <= '0;
      irq   <= '0;
      for (int i = 0; i < 4; i++) sh[i] <= '0;
      for (int c = 0; c < NCH; c++) begin
        st[c]  <= S_IDLE;
        dar[c] <= '0; cnt[c] <= '0; ctl[c] <= '0;
        src[c] <= '0; dst[c] <= '0; nxt[c] <= '0;
      end
    end else begin
      irq <= '0;
      if (!own_v) begin
        if (pick_v) begin
          own_v <= 1'b1;
          own   <= pick;
          widx  <= '0;
        end
      end else if (halt[own] || (accept && (mem_err || last_wd))) begin
        own_v <= 1'b0;
        widx  <= '0;
      end else if (accept) begin
        sh[widx[1:0]] <= mem_rdata;
        widx <= widx + 3'd1;
      end

      for (int c = 0; c < NCH; c++) begin
        if (reg_we && st[c] == S_IDLE) begin
          if (reg_addr == 8'(8*c))           dar[c] <= reg_wdata;
          if (reg_addr == 8'(8*c + 4))       cnt[c] <= reg_wdata;
          if (reg_addr == 8'(8'h40 + 8*c))   ctl[c] <= reg_wdata;
        end
        case (st[c])
          S_IDLE:  if (go[c]) st[c] <= S_FETCH;
          S_FETCH: begin
            if (halt[c]) st[c] <= S_IDLE;
            else if (accept && own == CHW'(c)) begin
              if (mem_err) begin
                st[c]  <= S_IDLE;
                irq[c] <= ctl[c][0] & cnt[c][ERR_B];
              end else if (last_wd) begin
                ctl[c] <= sh[0];
                src[c] <= sh[1];
                dst[c] <= sh[2];
                cnt[c] <= sh[3];
                nxt[c] <= mem_rdata;
                st[c]  <= S_XFER;
              end
            end
          end
          S_XFER: begin
            if (halt[c]) st[c] <= S_IDLE;
            else if (cnt[c][UW-1:0] == '0) begin
              irq[c] <= ctl[c][0] & (cnt[c][TC_B] | (cnt[c][EOC_B] & ~cnt[c][LINK_B]));
              if (cnt[c][LINK_B]) begin
                dar[c] <= nxt[c];
                st[c]  <= S_FETCH;
              end else begin
                st[c]  <= S_IDLE;
              end
            end else if (xfer_beat[c]) begin
              cnt[c][UW-1:0] <= cnt[c][UW-1:0] - UW'(1);
            end
          end
          default: st[c] <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CMD_OFS)
      for (int c = 0; c < NCH; c++) reg_rdata[c] = (st[c] != S_IDLE);
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == 8'(8*c))         reg_rdata = dar[c];
      if (reg_addr == 8'(8*c + 4))     reg_rdata = cnt[c];
      if (reg_addr == 8'(8'h40 + 8*c)) reg_rdata = ctl[c];
    end
  end

  always_comb
    for (int c = 0; c < NCH; c++) begin
      xfer_req[c]            = (st[c] == S_XFER) && (cnt[c][UW-1:0] != '0);
      xfer_src[c*32 +: 32]   = src[c];
      xfer_dst[c*32 +: 32]   = dst[c];
      xfer_bytes[c*BW +: BW] = BW'(cnt[c][UW-1:0]) << ctl[c][2:1];
    end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cmd_wr) |=> (mem_valid && $stable(mem_addr)));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      // R2
      no_mask_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[g] == S_IDLE && !(reg_we && reg_addr == CMD_OFS && reg_wdata[16+g])) |=> (st[g] == S_IDLE));
      // R6
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[g] |-> $past(ctl[g][0]));
      // R10
      dar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[g] == S_FETCH) |=> $stable(dar[g]));
      // R4
      units_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[g] == S_XFER && !xfer_beat[g]) |=> $stable(cnt[g][UW-1:0]));
    end
  endgenerate
endmodule

// File: tb/tb_sg_desc_walker.sv
module tb_sg_desc_walker;
  localparam int NCH = 2, UW = 16, BW = UW + 3;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [7:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_valid, mem_ready, mem_err; logic [31:0] mem_addr, mem_rdata;
  logic [NCH-1:0] xfer_req, irq; logic [NCH-1:0] xfer_beat = 0;
  logic [NCH*32-1:0] xfer_src, xfer_dst; logic [NCH*BW-1:0] xfer_bytes;

  always #10 clk = ~clk;

  sg_desc_walker #(.NCH(NCH), .UW(UW)) dut (.*);

  logic [31:0] mem [0:255];
  logic stall = 0, tick = 0, err_on = 0; logic [31:0] err_addr = 0;
  always @(posedge clk) tick <= ~tick;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = !stall || tick;
  assign mem_err   = err_on && (mem_addr == err_addr);

  int tests = 0, fails = 0; bit done = 0;
  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  typedef struct { logic [31:0] s, d; logic [BW-1:0] b; } xitem_t;
  xitem_t q0[$], q1[$];
  int irq_left [NCH];
  bit auto_beat = 1; int man_beats = 0;
  logic [NCH-1:0] req_prev = 0;

  always @(negedge clk) begin
    #2;
    for (int c = 0; c < NCH; c++) begin
      xfer_beat[c] = 0;
      if (xfer_req[c]) begin
        if (auto_beat) xfer_beat[c] = 1;
        else if (c == 1 && man_beats > 0) begin xfer_beat[c] = 1; man_beats--; end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < NCH; c++) begin
      if (xfer_req[c] && !req_prev[c]) begin
        xitem_t e; bit have;
        have = (c == 0) ? (q0.size() > 0) : (q1.size() > 0);
        if (!have) chk(0, "R4 unexpected transfer", xfer_src[c*32 +: 32], 0);
        else begin
          e = (c == 0) ? q0.pop_front() : q1.pop_front();
          chk(xfer_src[c*32 +: 32] == e.s, "R4 src", xfer_src[c*32 +: 32], e.s);
          chk(xfer_dst[c*32 +: 32] == e.d, "R4 dst", xfer_dst[c*32 +: 32], e.d);
          chk(xfer_bytes[c*BW +: BW] == e.b, "R4 bytes", 32'(xfer_bytes[c*BW +: BW]), 32'(e.b));
        end
      end
      if (irq[c]) begin
        if (irq_left[c] > 0) irq_left[c]--;
        else chk(0, "R6 unexpected irq", 1, 0);
      end
    end
    req_prev = xfer_req;
  end

  task automatic push(int c, logic [31:0] s, logic [31:0] d, int units, int w);
    xitem_t e; e.s = s; e.d = d; e.b = BW'(units) << w;
    if (c == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic put_desc(int a, logic [31:0] ct, logic [31:0] s, logic [31:0] d,
                          logic [31:0] cw, logic [31:0] n);
    mem[a/4] = ct; mem[a/4+1] = s; mem[a/4+2] = d; mem[a/4+3] = cw; mem[a/4+4] = n;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_idle(logic [31:0] m);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h80, v);
      if ((v & m) == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic end_test(string req);
    chk(q0.size() == 0 && q1.size() == 0, req, 32'(q0.size() + q1.size()), 0);
    chk(irq_left[0] == 0 && irq_left[1] == 0, req, 32'(irq_left[0] + irq_left[1]), 0);
  endtask

  localparam logic [31:0] LNK = 32'h8000_0000, TC = 32'h4000_0000,
                          EOC = 32'h2000_0000, ERE = 32'h1000_0000;

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    irq_left[0] = 0; irq_left[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h80, v); chk(v == 0, "R1 cmd", v, 0);
    chk(mem_valid == 0 && xfer_req == 0 && irq == 0, "R1 outputs",
        {mem_valid, xfer_req, irq}, 0);

    // R12 register spacing
    wr(8'h00, 32'h100); wr(8'h04, 32'h11); wr(8'h08, 32'h2C0); wr(8'h0C, 32'h22);
    rd(8'h00, v); chk(v == 32'h100, "R12 dar0", v, 32'h100);
    rd(8'h04, v); chk(v == 32'h11, "R12 cnt0", v, 32'h11);
    rd(8'h08, v); chk(v == 32'h2C0, "R12 dar1", v, 32'h2C0);
    rd(8'h0C, v); chk(v == 32'h22, "R12 cnt1", v, 32'h22);

    // R2 start bit without mask
    wr(8'h80, 32'h3);
    repeat (5) @(negedge clk);
    rd(8'h80, v); chk(v == 0, "R2 no mask no start", v, 0);
    chk(mem_valid == 0, "R2 no fetch", mem_valid, 0);

    // R3 R5 R7 three-descriptor chain with stalled memory
    stall = 1;
    put_desc(32'h100, 32'h1, 32'h1000, 32'h2000, LNK | 3, 32'h140);
    put_desc(32'h140, 32'h5, 32'h1100, 32'h2100, LNK | 0, 32'h180);
    put_desc(32'h180, 32'h7, 32'h3000, 32'h4000, TC | EOC | 5, 32'h0);
    push(0, 32'h1000, 32'h2000, 3, 0);
    push(0, 32'h3000, 32'h4000, 5, 3);
    irq_left[0] = 1;
    wr(8'h80, 32'h1_0001);
    wait_idle(1);
    rd(8'h80, v); chk(v == 0, "R5 stop on last", v, 0);
    rd(8'h40, v); chk(v == 32'h7, "R3 control reloaded", v, 32'h7);
    rd(8'h00, v); chk(v == 32'h180, "R5 dar at last", v, 32'h180);
    rd(8'h04, v); chk(v[15:0] == 0, "R4 count used up", v, 0);
    end_test("R7 zero-count chain");
    stall = 0;

    // R6 interrupt qualification
    put_desc(32'h200, 32'h3, 32'h10, 32'h20, LNK | EOC | 2, 32'h240);
    put_desc(32'h240, 32'h5, 32'h30, 32'h40, LNK | TC | 1, 32'h280);
    put_desc(32'h280, 32'h6, 32'h50, 32'h60, TC | EOC | 1, 32'h0);
    push(0, 32'h10, 32'h20, 2, 1);
    push(0, 32'h30, 32'h40, 1, 2);
    push(0, 32'h50, 32'h60, 1, 3);
    irq_left[0] = 1;
    wr(8'h00, 32'h200);
    wr(8'h80, 32'h1_0001);
    wait_idle(1);
    end_test("R6 irq flags");

    // R8 R10 halt with residue on channel 1
    auto_beat = 0;
    put_desc(32'h2C0, 32'h0, 32'h500, 32'h600, 32'd20, 32'h0);
    push(1, 32'h500, 32'h600, 20, 0);
    wr(8'h08, 32'h2C0);
    wr(8'h80, 32'h2_0002);
    for (int i = 0; i < 200 && !xfer_req[1]; i++) @(negedge clk);
    wr(8'h08, 32'h3F0);
    rd(8'h08, v); chk(v == 32'h2C0, "R10 busy write ignored", v, 32'h2C0);
    @(negedge clk); man_beats = 7;
    repeat (12) @(negedge clk);
    wr(8'h80, 32'h2_0000);
    chk(xfer_req[1] == 0, "R8 req dropped", xfer_req[1], 0);
    rd(8'h80, v); chk(v == 0, "R8 halted", v, 0);
    rd(8'h08, v); chk(v == 32'h2C0, "R8 dar kept", v, 32'h2C0);
    rd(8'h0C, v); chk(v[15:0] == 13, "R8 residue", v[15:0], 13);
    auto_beat = 1;
    end_test("R8 halt");

    // R9 read error on second descriptor
    put_desc(32'h300, 32'h1, 32'h700, 32'h800, LNK | ERE | 2, 32'h340);
    put_desc(32'h340, 32'h1, 32'h900, 32'hA00, 32'd2, 32'h0);
    err_on = 1; err_addr = 32'h348;
    push(0, 32'h700, 32'h800, 2, 0);
    irq_left[0] = 1;
    wr(8'h00, 32'h300);
    wr(8'h80, 32'h1_0001);
    wait_idle(1);
    rd(8'h00, v); chk(v == 32'h340, "R9 dar at failing desc", v, 32'h340);
    rd(8'h80, v); chk(v == 0, "R9 halted", v, 0);
    end_test("R9 error irq");
    err_on = 0;

    // R11 two channels, lower channel served first
    put_desc(32'h380, 32'h0, 32'hB00, 32'hC00, 32'd4, 32'h0);
    put_desc(32'h3C0, 32'h2, 32'hD00, 32'hE00, 32'd6, 32'h0);
    push(0, 32'hB00, 32'hC00, 4, 0);
    push(1, 32'hD00, 32'hE00, 6, 1);
    wr(8'h00, 32'h380); wr(8'h08, 32'h3C0);
    stall = 1;
    @(negedge clk); reg_we = 1; reg_addr = 8'h80; reg_wdata = 32'h3_0003;
    @(negedge clk); reg_we = 0;
    for (int i = 0; i < 50 && !mem_valid; i++) @(negedge clk);
    chk(mem_addr == 32'h380, "R11 lower channel first", mem_addr, 32'h380);
    wait_idle(3);
    stall = 0;
    end_test("R11 shared port");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule